// File: doc/BRIEF.md
# Array Configuration Controller with Stall Sequencing

This block is the central control point of a reconfigurable compute array. A test-port side command interface hands it one operation at a time. It keeps five small control registers: a scratch test word, a stall pattern with one bit per stall domain, a clock-select bit, a write-strobe delay word and a clock-switch delay bit. Register reads return their value on a read-data port one cycle later.

Two operations run for more than one cycle. A configuration write presents an address and a data word to the array. It holds a write strobe high for a number of cycles set by the delay register, then gives one low cycle. An advance command releases every stall domain for a counted number of cycles and then restores the saved stall pattern. While either runs, the controller shows busy and drops incoming commands.

Top module: `array_cfg_ctrl`

## Requirements
- R1: After a synchronous reset every register reads back zero, `stall_out` and `clk_sel_out` are 0, both array strobes are low and `busy` is low.
- R2: Opcodes on `cmd_op` are 0 no-op, 1 register write, 2 register read, 3 configuration write, 4 advance. The register index on `cmd_reg` is 0 test, 1 stall, 2 clock select, 3 write delay, 4 clock-switch delay. A read of a register returns the last value written to it, zero-extended, with `rd_valid` high for one cycle in the cycle after the command is taken. Narrow registers take the low bits of `cmd_data`.
- R3: A register write or read with an index of 5, 6 or 7 raises `err` for one cycle in the cycle after the command is taken. It changes no register and does not raise `rd_valid`.
- R4: A configuration write taken while the write delay register holds N keeps `cfg_wr` high for the N cycles that follow and then low for one more cycle. `busy` is high for all N+1 cycles. With N = 0 there is one low busy cycle.
- R5: `cfg_rd` stays low at all times, including during configuration writes.
- R6: For all N+1 cycles of a configuration write, `cfg_addr` and `cfg_data` carry the address and data given with the command, and they do not change.
- R7: An advance command with count C > 0 (taken from `cmd_addr`) drives `stall_out` to all zeros for the C cycles after it is taken, whatever bits `cmd_data` holds. `busy` is high for those C cycles. Afterwards `stall_out` and the stall register read back the pattern held before the command.
- R8: An advance command with C = 0 never raises `busy` and leaves `stall_out` unchanged.
- R9: A command presented while `busy` is high is dropped: no register changes and no read response or error results.
- R10: `clk_sel_out` follows bit 0 of the clock-select register from the cycle after it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is presented |
| cmd_op | input | 3 | Opcode |
| cmd_reg | input | 3 | Register index for register operations |
| cmd_addr | input | AW | Configuration address, or cycle count for advance |
| cmd_data | input | DW | Write data for a register or the array |
| busy | output | 1 | A multi-cycle sequence is running |
| err | output | 1 | One-cycle pulse for a bad register index |
| rd_valid | output | 1 | Read response is valid |
| rd_data | output | DW | Read response value |
| cfg_addr | output | AW | Configuration address to the array |
| cfg_data | output | DW | Configuration data to the array |
| cfg_wr | output | 1 | Configuration write strobe |
| cfg_rd | output | 1 | Configuration read strobe |
| stall_out | output | ND | Stall level per domain |
| clk_sel_out | output | 1 | Clock-select level |

## Verification
Each register gets a distinct bit pattern so that a read decoded from the wrong index would show. An out-of-range write is followed by reads of every register to show nothing moved. Configuration writes run with delays of 3, 0 and 1, which separates an off-by-one in strobe length from a missing low cycle. Commands are sent during busy windows to show they are dropped. Advance runs with counts of 4 and 0 over a nonzero stall pattern, which shows both the release window length and the exact restore.

// File: rtl/cfg_ctrl_pkg.sv
`timescale 1ns/1ps
package cfg_ctrl_pkg;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_REG_WR  = 3'd1,
        OP_REG_RD  = 3'd2,
        OP_CFG_WR  = 3'd3,
        OP_ADVANCE = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        RG_TEST   = 3'd0,
        RG_STALL  = 3'd1,
        RG_CLKSEL = 3'd2,
        RG_WRDLY  = 3'd3,
        RG_SWDLY  = 3'd4
    } reg_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_CFG  = 2'd1,
        SQ_ADV  = 2'd2
    } seq_e;

    function automatic logic reg_index_ok(input logic [2:0] idx);
        return idx <= 3'(RG_SWDLY);
    endfunction

endpackage

// File: rtl/cfg_ctrl_regs.sv
`timescale 1ns/1ps
module cfg_ctrl_regs
    import cfg_ctrl_pkg::*;
#(
    parameter int DW = 16,
    parameter int ND = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic [2:0]    op,
    input  logic [2:0]    idx,
    input  logic [DW-1:0] data,
    output logic [ND-1:0] stall_q,
    output logic          clk_sel_q,
    output logic [DW-1:0] wr_dly_q,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          err
);
    logic [DW-1:0] test_q;
    logic          sw_dly_q;
    logic          is_wr, is_rd, idx_ok;
    logic [DW-1:0] rd_mux;

    assign is_wr  = accept && (op == 3'(OP_REG_WR));
    assign is_rd  = accept && (op == 3'(OP_REG_RD));
    assign idx_ok = reg_index_ok(idx);

    always_comb begin
        case (idx)
            3'(RG_TEST):   rd_mux = test_q;
            3'(RG_STALL):  rd_mux = DW'(stall_q);
            3'(RG_CLKSEL): rd_mux = DW'(clk_sel_q);
            3'(RG_WRDLY):  rd_mux = wr_dly_q;
            3'(RG_SWDLY):  rd_mux = DW'(sw_dly_q);
            default:       rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            test_q    <= '0;
            stall_q   <= '0;
            clk_sel_q <= 1'b0;
            wr_dly_q  <= '0;
            sw_dly_q  <= 1'b0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            err       <= 1'b0;
        end else begin
            rd_valid <= is_rd && idx_ok;
            err      <= (is_wr || is_rd) && !idx_ok;
            if (is_rd && idx_ok) rd_data <= rd_mux;
            if (is_wr) begin
                case (idx)
                    3'(RG_TEST):   test_q    <= data;
                    3'(RG_STALL):  stall_q   <= data[ND-1:0];
                    3'(RG_CLKSEL): clk_sel_q <= data[0];
                    3'(RG_WRDLY):  wr_dly_q  <= data;
                    3'(RG_SWDLY):  sw_dly_q  <= data[0];
                    default: ;
                endcase
            end
        end
    end

    // R3
    bad_write_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        (is_wr && !idx_ok) |=> ($stable(test_q) && $stable(stall_q) &&
                                $stable(clk_sel_q) && $stable(wr_dly_q) &&
                                $stable(sw_dly_q)));
    // R3
    err_excludes_read_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> !rd_valid);
    // R2
    read_follows_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(is_rd));
endmodule

// File: rtl/cfg_ctrl_seq.sv
`timescale 1ns/1ps
module cfg_ctrl_seq
    import cfg_ctrl_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic [2:0]    op,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    input  logic [DW-1:0] wr_dly,
    output logic          busy,
    output logic          cfg_wr,
    output logic          adv_active,
    output logic [AW-1:0] cfg_addr,
    output logic [DW-1:0] cfg_data
);
    localparam int CNTW = (DW > AW) ? DW : AW;

    seq_e            state;
    logic [CNTW-1:0] rem;

    assign busy       = (state != SQ_IDLE);
    assign adv_active = (state == SQ_ADV);
    assign cfg_wr     = (state == SQ_CFG) && (rem != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            rem      <= '0;
            cfg_addr <= '0;
            cfg_data <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (accept && op == 3'(OP_CFG_WR)) begin
                        state    <= SQ_CFG;
                        rem      <= CNTW'(wr_dly);
                        cfg_addr <= addr;
                        cfg_data <= data;
                    end else if (accept && op == 3'(OP_ADVANCE) && addr != '0) begin
                        state <= SQ_ADV;
                        rem   <= CNTW'(addr) - CNTW'(1);
                    end
                end
                default: begin
                    if (rem == '0) state <= SQ_IDLE;
                    else           rem   <= rem - CNTW'(1);
                end
            endcase
        end
    end

    // R4
    strobe_inside_busy_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |-> busy);
    // R4
    cfg_ends_after_low_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_CFG && !cfg_wr) |=> !busy);
    // R6
    cfg_fields_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_CFG && $past(state == SQ_CFG)) |->
            ($stable(cfg_addr) && $stable(cfg_data)));
endmodule

// File: rtl/array_cfg_ctrl.sv
`timescale 1ns/1ps
module array_cfg_ctrl
    import cfg_ctrl_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 12,
    parameter int ND = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [2:0]    cmd_reg,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    output logic          busy,
    output logic          err,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] cfg_addr,
    output logic [DW-1:0] cfg_data,
    output logic          cfg_wr,
    output logic          cfg_rd,
    output logic [ND-1:0] stall_out,
    output logic          clk_sel_out
);
    logic          accept;
    logic          adv_active;
    logic [ND-1:0] stall_q;
    logic [DW-1:0] wr_dly_q;

    assign accept = cmd_valid && !busy;

    cfg_ctrl_regs #(.DW(DW), .ND(ND)) u_regs (
        .clk(clk), .rst(rst), .accept(accept), .op(cmd_op), .idx(cmd_reg),
        .data(cmd_data), .stall_q(stall_q), .clk_sel_q(clk_sel_out),
        .wr_dly_q(wr_dly_q), .rd_valid(rd_valid), .rd_data(rd_data), .err(err)
    );

    cfg_ctrl_seq #(.DW(DW), .AW(AW)) u_seq (
        .clk(clk), .rst(rst), .accept(accept), .op(cmd_op), .addr(cmd_addr),
        .data(cmd_data), .wr_dly(wr_dly_q), .busy(busy), .cfg_wr(cfg_wr),
        .adv_active(adv_active), .cfg_addr(cfg_addr), .cfg_data(cfg_data)
    );

    assign cfg_rd    = 1'b0;
    assign stall_out = adv_active ? '0 : stall_q;

    // R7
    release_window_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !cfg_wr && $past(busy) && $stable(stall_q) && stall_out != stall_q) |->
            (stall_out == '0));
    // R9
    busy_drops_read_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && busy) |=> !rd_valid && !err);
endmodule

// File: tb/array_cfg_ctrl_test.sv
`timescale 1ns/1ps
module array_cfg_ctrl_test;
    localparam int DW = 16;
    localparam int AW = 12;
    localparam int ND = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [2:0]    cmd_reg = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic          busy, err, rd_valid, cfg_wr, cfg_rd, clk_sel_out;
    logic [DW-1:0] rd_data, cfg_data;
    logic [AW-1:0] cfg_addr;
    logic [ND-1:0] stall_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    array_cfg_ctrl #(.DW(DW), .AW(AW), .ND(ND)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_reg(cmd_reg), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .busy(busy), .err(err), .rd_valid(rd_valid), .rd_data(rd_data),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .cfg_wr(cfg_wr),
        .cfg_rd(cfg_rd), .stall_out(stall_out), .clk_sel_out(clk_sel_out)
    );

    always #2.5 clk = ~clk;

    // behavioural reference model
    int m_test, m_stall, m_sel, m_dly, m_sw;
    int wr_left, low_left, adv_left;
    int e_rv, e_rd, e_err, e_addr, e_data;

    always @(posedge clk) begin
        if (rst) begin
            m_test = 0; m_stall = 0; m_sel = 0; m_dly = 0; m_sw = 0;
            wr_left = 0; low_left = 0; adv_left = 0;
            e_rv = 0; e_rd = 0; e_err = 0; e_addr = 0; e_data = 0;
        end else begin
            e_rv = 0; e_err = 0;
            if (wr_left + low_left + adv_left > 0) begin
                if (wr_left > 0)       wr_left--;
                else if (low_left > 0) low_left--;
                else                   adv_left--;
            end else if (cmd_valid) begin
                case (int'(cmd_op))
                    1: case (int'(cmd_reg))
                        0: m_test = int'(cmd_data);
                        1: m_stall = int'(cmd_data) % (1 << ND);
                        2: m_sel = int'(cmd_data) % 2;
                        3: m_dly = int'(cmd_data);
                        4: m_sw = int'(cmd_data) % 2;
                        default: e_err = 1;
                       endcase
                    2: case (int'(cmd_reg))
                        0: begin e_rv = 1; e_rd = m_test;  end
                        1: begin e_rv = 1; e_rd = m_stall; end
                        2: begin e_rv = 1; e_rd = m_sel;   end
                        3: begin e_rv = 1; e_rd = m_dly;   end
                        4: begin e_rv = 1; e_rd = m_sw;    end
                        default: e_err = 1;
                       endcase
                    3: begin
                        wr_left = m_dly; low_left = 1;
                        e_addr = int'(cmd_addr); e_data = int'(cmd_data);
                    end
                    4: adv_left = int'(cmd_addr);
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R4", "busy", int'(busy), (wr_left + low_left + adv_left > 0) ? 1 : 0);
            chk("R4", "cfg_wr", int'(cfg_wr), (wr_left > 0) ? 1 : 0);
            chk("R5", "cfg_rd", int'(cfg_rd), 0);
            chk("R7", "stall_out", int'(stall_out), (adv_left > 0) ? 0 : m_stall);
            chk("R10", "clk_sel_out", int'(clk_sel_out), m_sel);
            chk("R2", "rd_valid", int'(rd_valid), e_rv);
            chk("R3", "err", int'(err), e_err);
            if (e_rv != 0) chk("R2", "rd_data", int'(rd_data), e_rd);
            if (wr_left + low_left > 0) begin
                chk("R6", "cfg_addr", int'(cfg_addr), e_addr);
                chk("R6", "cfg_data", int'(cfg_data), e_data);
            end
        end
    end

    task automatic issue(input int op, input int rg, input int ad, input int dt);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 3'(op);
        cmd_reg   = 3'(rg);
        cmd_addr  = AW'(ad);
        cmd_data  = DW'(dt);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_all();
        for (int i = 0; i < 5; i++) issue(2, i, 0, 0);
    endtask

    initial begin
        #250000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        read_all();
        // R2, R10: distinct patterns per register
        issue(1, 0, 0, 'hA5C3);
        issue(1, 1, 0, 'h000B);
        issue(1, 2, 0, 'h0001);
        issue(1, 3, 0, 'h0003);
        issue(1, 4, 0, 'h0001);
        read_all();
        // R3: bad index write and read
        issue(1, 6, 0, 'hFFFF);
        issue(2, 7, 0, 0);
        read_all();
        // R4, R6, R9: delay 3, command during busy dropped
        issue(3, 0, 'h3A5, 'hBEEF);
        issue(1, 0, 0, 'h1234);
        issue(2, 0, 0, 0);
        idle(4);
        issue(2, 0, 0, 0);
        // R4: delay 0
        issue(1, 3, 0, 0);
        issue(3, 0, 'h05A, 'h0F0F);
        idle(3);
        // R4: delay 1 back to back
        issue(1, 3, 0, 1);
        issue(3, 0, 'h7FF, 'h8001);
        issue(3, 0, 'h001, 'h1111);
        idle(4);
        // R7: release window of 4, R9 advance dropped
        issue(4, 0, 4, 'hF);
        issue(4, 0, 9, 0);
        idle(6);
        issue(2, 1, 0, 0);
        // R8: zero count
        issue(4, 0, 0, 'hF);
        issue(2, 1, 0, 0);
        // R10: clock select back to 0
        issue(1, 2, 0, 'hFFFE);
        idle(3);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule